// File: doc/BRIEF.md
# Float Immediate Constant Loader

This block turns 16-bit immediates into 64-bit floating-point register values, so that software can build a constant without a memory read. A load operation treats the immediate as the top half of a single-precision word, with the bottom half zero. That is the same as reading it as a brain-float value. The block widens the word to double precision and presents it for write-back.

An insert operation finishes a constant that a previous load started. It reads the current double-precision register value and narrows it back to single precision, using the bit-selection rule of a single-precision store. It keeps only the upper sixteen bits of that word and puts the new immediate in the lower sixteen. It then widens the word again. The register file supplies the old value and accepts the result.

Neither operation raises or changes any floating-point status. Results appear one cycle after the request.

Top module: `fimm_loader`

## Requirements
- R1: While reset is asserted and after its release with no request, `wr_en` is 0 and `wr_data` is all zeros.
- R2: A request sampled with `op_valid`=1 at a rising edge gives `wr_en`=1 for exactly the following cycle, with its result on `wr_data`. Cycles without a request give `wr_en`=0, and `wr_data` holds its last value.
- R3: With `op_sel`=0 (load), the result is the double-precision value of the single-precision word {imm, 16'h0}. Examples: 0x3F80 gives 0x3FF0_0000_0000_0000, 0xBFC0 gives 0xBFF8_0000_0000_0000 and 0x3FFF gives 0x3FFF_E000_0000_0000.
- R4: A single-precision exponent of all ones widens to the double exponent 0x7FF, and the mantissa bits are kept. Examples: 0x7F80 gives 0x7FF0_0000_0000_0000, 0xFF80 gives 0xFFF0_0000_0000_0000 and 0x7FC0 gives quiet NaN 0x7FF8_0000_0000_0000.
- R5: A single-precision denormal is normalised exactly on widening. Examples: load 0x0001 gives 0x37A0_0000_0000_0000 and load 0x0060 gives 0x3808_0000_0000_0000.
- R6: With `op_sel`=1 (insert), `reg_rdata` is narrowed to single precision. Bits 15:0 of that word are replaced by `imm`, and the word is widened again. Example: 0x3FF0_0000_0000_0000 with imm 0x8000 gives 0x3FF0_1000_0000_0000.
- R7: An insert ignores `reg_rdata` bits 44:0 when the register exponent lies above the single denormal range. Those bits are the ones below the upper sixteen bits of the narrowed word.
- R8: For a register exponent from 874 to 896, narrowing shifts {1, mantissa} right by (897 − exponent) and keeps a zero single exponent. Example: 0x3800_0000_0000_0000 with imm 0x0001 gives 0x3800_0000_4000_0000.
- R9: The sign passes through both operations. Load 0x8000 gives 0x8000_0000_0000_0000 (−0.0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Request strobe |
| op_sel | input | 1 | 0 = load upper half, 1 = insert lower half |
| imm | input | 16 | Immediate operand |
| reg_rdata | input | 64 | Current register value (used by insert) |
| wr_en | output | 1 | Result write strobe |
| wr_data | output | 64 | Double-precision result |

## Verification
The hardest path to reach is the denormal branch of the narrowing step. A load only produces such register values from a zero single exponent, and a chained sequence hides which step went wrong. The stimulus therefore drives `reg_rdata` directly with double exponents at both ends of the 874 to 896 window. It also presents register values whose discarded low bits are all ones. The denormal branch of widening is reached separately through loads with a zero immediate exponent.

// File: rtl/fimm_pkg.sv
package fimm_pkg;
  localparam int IMM_W    = 16;
  localparam int SP_W     = 2 * IMM_W;
  localparam int SP_EXP_W = 8;
  localparam int SP_MAN_W = SP_W - 1 - SP_EXP_W;
  localparam int DP_W     = 64;
  localparam int DP_EXP_W = 11;
  localparam int DP_MAN_W = DP_W - 1 - DP_EXP_W;
  localparam int SP_BIAS  = (1 << (SP_EXP_W - 1)) - 1;
  localparam int DP_BIAS  = (1 << (DP_EXP_W - 1)) - 1;
  localparam int MAN_GAP  = DP_MAN_W - SP_MAN_W;
  // double exponent of the smallest normal single, minus one
  localparam int SUB_TOP  = DP_BIAS - SP_BIAS;
  // double exponent of the smallest single denormal
  localparam int SUB_BOT  = SUB_TOP - SP_MAN_W + 1;
  localparam int LEAD_W   = $clog2(SP_MAN_W);

  typedef enum logic {
    OP_LOAD   = 1'b0,
    OP_INSERT = 1'b1
  } fimm_op_e;

  typedef struct packed {
    logic                sign;
    logic [SP_EXP_W-1:0] exp;
    logic [SP_MAN_W-1:0] man;
  } sp_word_t;

  typedef struct packed {
    logic                sign;
    logic [DP_EXP_W-1:0] exp;
    logic [DP_MAN_W-1:0] man;
  } dp_word_t;
endpackage

// File: rtl/fimm_widen.sv
module fimm_widen
  import fimm_pkg::*;
(
  input  logic [SP_W-1:0] sp_in,
  output logic [DP_W-1:0] dp_out
);
  sp_word_t            src;
  dp_word_t            res;
  logic [LEAD_W-1:0]   lead;
  logic                found;
  logic [SP_MAN_W-1:0] norm;

  assign src = sp_word_t'(sp_in);

  // position of the leading one in a denormal mantissa
  always_comb begin
    lead  = '0;
    found = 1'b0;
    for (int i = SP_MAN_W - 1; i >= 0; i--) begin
      if (!found && src.man[i]) begin
        lead  = LEAD_W'(i);
        found = 1'b1;
      end
    end
  end

  assign norm = src.man << (SP_MAN_W - int'(lead));

  always_comb begin
    res.sign = src.sign;
    if (src.exp == '1) begin
      res.exp = '1;
      res.man = {src.man, {MAN_GAP{1'b0}}};
    end else if (src.exp != '0) begin
      res.exp = DP_EXP_W'(src.exp) + DP_EXP_W'(SUB_TOP);
      res.man = {src.man, {MAN_GAP{1'b0}}};
    end else if (found) begin
      res.exp = DP_EXP_W'(lead) + DP_EXP_W'(SUB_BOT);
      res.man = {norm, {MAN_GAP{1'b0}}};
    end else begin
      res.exp = '0;
      res.man = '0;
    end
  end

  assign dp_out = DP_W'(res);
endmodule

// File: rtl/fimm_narrow_hi.sv
module fimm_narrow_hi
  import fimm_pkg::*;
(
  input  logic [DP_W-1:0]  dp_in,
  output logic [IMM_W-1:0] sp_hi
);
  localparam int HI_MAN_W = IMM_W - 1 - SP_EXP_W;
  localparam int SEL_LO   = DP_MAN_W - HI_MAN_W;

  dp_word_t            src;
  logic                in_sub;
  logic [DP_EXP_W-1:0] shamt;
  logic [DP_MAN_W:0]   frac;

  assign src    = dp_word_t'(dp_in);
  assign in_sub = (src.exp >= DP_EXP_W'(SUB_BOT)) && (src.exp <= DP_EXP_W'(SUB_TOP));
  assign shamt  = DP_EXP_W'(SUB_TOP + 1) - src.exp;
  assign frac   = {1'b1, src.man};

  always_comb begin
    if (in_sub) begin
      sp_hi = {src.sign, {SP_EXP_W{1'b0}},
               HI_MAN_W'(frac >> (int'(shamt) + SEL_LO))};
    end else begin
      sp_hi = {src.sign, src.exp[DP_EXP_W-1],
               src.exp[SP_EXP_W-2:0], src.man[DP_MAN_W-1:SEL_LO]};
    end
  end
endmodule

// File: rtl/fimm_loader.sv
module fimm_loader
  import fimm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             op_sel,
  input  logic [IMM_W-1:0] imm,
  input  logic [DP_W-1:0]  reg_rdata,
  output logic             wr_en,
  output logic [DP_W-1:0]  wr_data
);
  logic [IMM_W-1:0] old_hi;
  logic [SP_W-1:0]  sp_word;
  logic [DP_W-1:0]  wide;
  logic             wr_en_d;
  logic [DP_W-1:0]  wr_data_d;

  fimm_narrow_hi u_narrow (
    .dp_in (reg_rdata),
    .sp_hi (old_hi)
  );

  always_comb begin
    if (fimm_op_e'(op_sel) == OP_INSERT) sp_word = {old_hi, imm};
    else                                 sp_word = {imm, {IMM_W{1'b0}}};
  end

  fimm_widen u_widen (
    .sp_in  (sp_word),
    .dp_out (wide)
  );

  always_comb begin
    wr_en_d   = op_valid;
    wr_data_d = wr_data;
    if (op_valid) wr_data_d = wide;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_en   <= wr_en_d;
      wr_data <= wr_data_d;
    end
  end
endmodule

// File: rtl/fimm_loader_chk.sv
module fimm_loader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic        op_sel,
  input logic [15:0] imm,
  input logic [18:0] reg_hi,
  input logic        wr_en,
  input logic [63:0] wr_data
);
  assert_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> wr_en);
  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!wr_en && $stable(wr_data)));
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |-> (!wr_en && wr_data == 64'h0));
  assert_load_exp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_sel && imm[14:7] != 8'h00 && imm[14:7] != 8'hFF)
    |=> wr_data[62:52] == (11'($past(imm[14:7])) + 11'd896));
  assert_special_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_sel && imm[14:7] == 8'hFF)
    |=> (wr_data[62:52] == 11'h7FF && wr_data[51:45] == $past(imm[6:0])));
  assert_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_sel) |=> wr_data[63] == $past(imm[15]));
  assert_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> wr_data[28:0] == 29'h0);
  assert_insert_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel && reg_hi[17:7] >= 11'd897 && reg_hi[17:7] <= 11'd1150)
    |=> (wr_data[63:45] == $past(reg_hi) && wr_data[44:29] == $past(imm)));
endmodule

bind fimm_loader fimm_loader_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_sel   (op_sel),
  .imm      (imm),
  .reg_hi   (reg_rdata[63:45]),
  .wr_en    (wr_en),
  .wr_data  (wr_data)
);

// File: tb/fimm_loader_tb.sv
module fimm_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic        op_sel;
  logic [15:0] imm;
  logic [63:0] reg_rdata;
  logic        wr_en;
  logic [63:0] wr_data;

  int n_chk = 0;
  int n_bad = 0;
  bit run_done = 1'b0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] last_data;

  always #2 clk = ~clk;

  fimm_loader u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .imm(imm), .reg_rdata(reg_rdata), .wr_en(wr_en), .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic issue(input logic sel, input logic [15:0] im,
                       input logic [63:0] rd, input logic [63:0] expv,
                       input string tag);
    @(negedge clk);
    op_valid  = 1'b1;
    op_sel    = sel;
    imm       = im;
    reg_rdata = rd;
    exp_q.push_back(expv);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      op_valid  = 1'b0;
      op_sel    = ~op_sel;
      imm       = 16'hA5C3 ^ 16'(k);
      reg_rdata = ~reg_rdata;
    end
  endtask

  // monitor: pops the scoreboard as results appear
  initial begin
    last_data = 64'h0;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      #1;
      if (wr_en) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 strobe without request", {63'h0, wr_en}, 64'h0);
        end else begin
          logic [63:0] e;
          string       t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(wr_data === e, t, wr_data, e);
        end
        last_data = wr_data;
      end else begin
        check(wr_data === last_data, "R2 hold while idle", wr_data, last_data);
      end
    end
  end

  initial begin
    rst_n     = 1'b0;
    op_valid  = 1'b0;
    op_sel    = 1'b0;
    imm       = 16'h0;
    reg_rdata = 64'h0;
    repeat (3) @(negedge clk);
    check(wr_en === 1'b0, "R1 wr_en in reset", {63'h0, wr_en}, 64'h0);
    check(wr_data === 64'h0, "R1 wr_data in reset", wr_data, 64'h0);
    rst_n = 1'b1;
    idle(2);

    issue(1'b0, 16'h0000, 64'h0, 64'h0000_0000_0000_0000, "R3 load +0.0");
    issue(1'b0, 16'h8000, 64'h0, 64'h8000_0000_0000_0000, "R9 load -0.0");
    issue(1'b0, 16'h3F80, 64'h0, 64'h3FF0_0000_0000_0000, "R3 load 1.0");
    issue(1'b0, 16'hBFC0, 64'h0, 64'hBFF8_0000_0000_0000, "R3 R9 load -1.5");
    issue(1'b0, 16'h3FFF, 64'h0, 64'h3FFF_E000_0000_0000, "R3 load 1.9921875");
    issue(1'b0, 16'h7F80, 64'h0, 64'h7FF0_0000_0000_0000, "R4 load +Inf");
    issue(1'b0, 16'hFF80, 64'h0, 64'hFFF0_0000_0000_0000, "R4 load -Inf");
    issue(1'b0, 16'h7FC0, 64'h0, 64'h7FF8_0000_0000_0000, "R4 load qNaN");
    idle(3);
    issue(1'b0, 16'h0001, 64'h0, 64'h37A0_0000_0000_0000, "R5 load denormal 0x0001");
    issue(1'b0, 16'h0040, 64'h0, 64'h3800_0000_0000_0000, "R5 load denormal 0x0040");
    issue(1'b0, 16'h0060, 64'h0, 64'h3808_0000_0000_0000, "R5 load denormal 0x0060");
    issue(1'b1, 16'h8000, 64'h3FF0_0000_0000_0000, 64'h3FF0_1000_0000_0000, "R6 insert after 1.0");
    issue(1'b1, 16'h1234, 64'hBFF8_0000_0000_0000, 64'hBFF8_0246_8000_0000, "R6 R9 insert negative");
    issue(1'b1, 16'h8000, 64'h3FF0_0000_1FFF_FFFF, 64'h3FF0_1000_0000_0000, "R7 insert ignores bits below 29");
    issue(1'b1, 16'h0000, 64'h3FF0_1FFF_E000_0000, 64'h3FF0_0000_0000_0000, "R7 insert replaces old low half");
    issue(1'b1, 16'h0001, 64'h7FF0_0000_0000_0000, 64'h7FF0_0000_2000_0000, "R4 insert NaN payload");
    idle(2);
    issue(1'b1, 16'h0001, 64'h3800_0000_0000_0000, 64'h3800_0000_4000_0000, "R8 insert at exponent 896");
    issue(1'b1, 16'h0003, 64'h36A0_0000_0000_0000, 64'h36B8_0000_0000_0000, "R8 insert at exponent 874");
    issue(1'b1, 16'h0000, 64'h36A0_0000_0000_0000, 64'h0000_0000_0000_0000, "R8 insert clears smallest denormal");
    issue(1'b1, 16'h0001, 64'h0000_0000_0000_0000, 64'h36A0_0000_0000_0000, "R6 insert onto zero");
    idle(4);
    check(exp_q.size() == 0, "R2 every request written", 64'(exp_q.size()), 64'h0);
    run_done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!run_done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule